// File: doc/BRIEF.md
# Two-Level Carry Lookahead Adder

This block adds two 16-bit unsigned operands and an incoming carry, and returns a 16-bit sum and an outgoing carry. It has no clock and no registers, so the result depends only on the present inputs. Every bit position forms a propagate term (the XOR of its two operand bits) and a generate term (their AND). The operand is cut into four 4-bit groups. Each group computes the carries into its own bits in parallel from these terms, and it also reports one group propagate and one group generate.

A second-level lookahead unit applies the same carry equations to the four group propagate/generate pairs. It produces the carry into each group and the final carry-out. No carry travels through more than two lookahead levels, so the critical path stays near five gate delays. A 16-stage ripple chain needs about thirty-two. The block is meant to sit inside a datapath, where an add result is needed in the same cycle as its operands.

Top module: `cla_adder16`

## Requirements
- R1: `sum` equals the low 16 bits of the arithmetic sum `opa + opb + cin`, for every input combination.
- R2: `cout` equals bit 16 of the 17-bit arithmetic sum `opa + opb + cin`. This includes 0xFFFF + 0x0000 with `cin`=1, which gives `sum`=0x0000 and `cout`=1.
- R3: A bit pair of 0/0 stops a carry: the carry out of that bit is 0 whatever arrives. A pair of 1/1 makes a carry: the carry out of that bit is 1 whatever arrives. A pair of 0/1 or 1/0 passes the incoming carry on unchanged.
- R4: A group whose four bit pairs all pass a carry (group propagate = 1) hands the carry it receives straight on to the next group. With `opa`=0x5555, `opb`=0xAAAA and `cin`=1, the carry crosses all four groups and the result is `sum`=0x0000, `cout`=1.
- R5: A group whose bits create a carry internally (group generate = 1) delivers carry 1 to the next group, independent of `cin`.
- R6: Each sum bit i equals `opa[i] XOR opb[i] XOR c_i`. Here c_i is the carry into bit i: c_0 = `cin`, and c_i for i > 0 is bit i of `(opa mod 2^i) + (opb mod 2^i) + cin`.
- R7: The block holds no state. The outputs follow a change of inputs within the same time step, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| cin | input | 1 | Incoming carry to bit 0 |
| sum | output | 16 | Low 16 bits of the addition |
| cout | output | 1 | Carry out of bit 15 |

## Verification
The operand patterns are chosen so that each one exercises a different carry path:
- Alternating bits (0x5555 + 0xAAAA) make every bit pass a carry, so only the carry-in can decide the result. This separates correct group-propagate handling from a chain that is broken at a group boundary.
- Operands such as 0x000F + 0x0001 and 0x00F0 + 0x0010 create a carry inside one group and send it into an upper group. This exercises the group generate path on its own, apart from the carry-in.
- All-ones plus one, and zero plus zero, cover the extreme carry-out values.
- A long run of pseudo-random operands is checked against both the whole sum and the carry into every individual bit. This catches a wrong product term in either lookahead level.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned SUM_W   = 16;
  localparam int unsigned GROUP_W = 4;
  localparam int unsigned NUM_GRP = SUM_W / GROUP_W;

  // kill / pass / make classification of a bit or group
  typedef struct packed {
    logic pass;
    logic make;
  } pg_t;

  function automatic pg_t classify(input logic x, input logic y);
    pg_t r;
    r.pass = x ^ y;
    r.make = x & y;
    return r;
  endfunction
endpackage

// File: rtl/cla_unit.sv
// Lookahead carry unit: carries into N positions from pass/make terms,
// expanded as flat sum-of-products, plus block pass/make outputs.
module cla_unit #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] pass_i,
  input  logic [N-1:0] make_i,
  input  logic         cin,
  output logic [N-1:0] carry_o,
  output logic         blk_pass,
  output logic         blk_make
);
  always_comb begin
    logic acc;
    logic prod;
    carry_o[0] = cin;
    for (int j = 0; j < int'(N) - 1; j++) begin
      acc  = 1'b0;
      prod = 1'b1;
      for (int k = j; k >= 0; k--) begin
        acc  = acc | (prod & make_i[k]);
        prod = prod & pass_i[k];
      end
      carry_o[j+1] = acc | (prod & cin);
    end
  end

  always_comb begin
    logic acc;
    logic prod;
    acc  = 1'b0;
    prod = 1'b1;
    for (int k = int'(N) - 1; k >= 0; k--) begin
      acc  = acc | (prod & make_i[k]);
      prod = prod & pass_i[k];
    end
    blk_make = acc;
    blk_pass = prod;
  end
endmodule

// File: rtl/cla_group.sv
// One first-level group: bit classification, internal carries, sums.
module cla_group
  import cla_pkg::*;
#(
  parameter int unsigned W = GROUP_W
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         grp_pass,
  output logic         grp_make
);
  logic [W-1:0] bit_pass;
  logic [W-1:0] bit_make;
  logic [W-1:0] bit_carry;

  for (genvar i = 0; i < W; i++) begin : g_bit
    pg_t t;
    assign t           = classify(x[i], y[i]);
    assign bit_pass[i] = t.pass;
    assign bit_make[i] = t.make;
  end

  cla_unit #(.N(W)) u_look (
    .pass_i  (bit_pass),
    .make_i  (bit_make),
    .cin     (cin),
    .carry_o (bit_carry),
    .blk_pass(grp_pass),
    .blk_make(grp_make)
  );

  assign s = bit_pass ^ bit_carry;
endmodule

// File: rtl/cla_adder16.sv
// Two-level carry lookahead adder, top level.
module cla_adder16
  import cla_pkg::*;
(
  input  logic [SUM_W-1:0] opa,
  input  logic [SUM_W-1:0] opb,
  input  logic             cin,
  output logic [SUM_W-1:0] sum,
  output logic             cout
);
  logic [NUM_GRP-1:0] grp_pass;
  logic [NUM_GRP-1:0] grp_make;
  logic [NUM_GRP-1:0] grp_carry;
  logic               top_pass;
  logic               top_make;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    cla_group #(.W(GROUP_W)) u_grp (
      .x       (opa[g*GROUP_W +: GROUP_W]),
      .y       (opb[g*GROUP_W +: GROUP_W]),
      .cin     (grp_carry[g]),
      .s       (sum[g*GROUP_W +: GROUP_W]),
      .grp_pass(grp_pass[g]),
      .grp_make(grp_make[g])
    );
  end

  // second level: same equations over group terms
  cla_unit #(.N(NUM_GRP)) u_level2 (
    .pass_i  (grp_pass),
    .make_i  (grp_make),
    .cin     (cin),
    .carry_o (grp_carry),
    .blk_pass(top_pass),
    .blk_make(top_make)
  );

  assign cout = top_make | (top_pass & cin);
endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk
  import cla_pkg::*;
(
  input logic [SUM_W-1:0]   opa,
  input logic [SUM_W-1:0]   opb,
  input logic               cin,
  input logic [SUM_W-1:0]   sum,
  input logic               cout,
  input logic [NUM_GRP-1:0] grp_pass,
  input logic [NUM_GRP-1:0] grp_make,
  input logic [NUM_GRP-1:0] grp_carry
);
  logic [SUM_W:0] ref_sum;
  assign ref_sum = {1'b0, opa} + {1'b0, opb} + {{SUM_W{1'b0}}, cin};

  always_comb begin
    if (!$isunknown({opa, opb, cin})) begin
      assert_sum_R1: assert (sum == ref_sum[SUM_W-1:0])
        else $error("sum mismatch");
      assert_cout_R2: assert (cout == ref_sum[SUM_W])
        else $error("carry-out mismatch");
      for (int k = 0; k < int'(NUM_GRP) - 1; k++) begin
        if (grp_pass[k]) begin
          assert_grp_pass_R4: assert (grp_carry[k+1] == grp_carry[k])
            else $error("group pass broke chain");
        end
        if (grp_make[k]) begin
          assert_grp_make_R5: assert (grp_carry[k+1])
            else $error("group make lost carry");
        end
      end
    end
  end
endmodule

bind cla_adder16 cla_adder_chk u_chk (
  .opa      (opa),
  .opb      (opb),
  .cin      (cin),
  .sum      (sum),
  .cout     (cout),
  .grp_pass (grp_pass),
  .grp_make (grp_make),
  .grp_carry(grp_carry)
);

// File: tb/tb_cla_adder16.sv
`timescale 1ns/1ps
module tb_cla_adder16;
  logic        clk;
  logic        rst_n;
  logic [15:0] opa;
  logic [15:0] opb;
  logic        cin;
  logic [15:0] sum;
  logic        cout;

  int n_run;
  int n_fail;
  logic done;

  cla_adder16 dut (.opa(opa), .opb(opb), .cin(cin), .sum(sum), .cout(cout));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (opa=%h opb=%h cin=%b)", req, act, exp, opa, opb, cin);
    end
  endtask

  // drive on rising edge, compare on falling edge
  task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic c);
    int full;
    @(posedge clk);
    opa = x; opb = y; cin = c;
    @(negedge clk);
    full = int'(x) + int'(y) + int'(c);
    check("R1", {16'h0, sum}, full & 32'hFFFF);
    check("R2", {31'h0, cout}, (full >> 16) & 1);
  endtask

  task automatic check_bits(input logic [15:0] x, input logic [15:0] y, input logic c);
    int ci;
    @(posedge clk);
    opa = x; opb = y; cin = c;
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      ci = (i == 0) ? int'(c)
         : (((int'(x) % (1 << i)) + (int'(y) % (1 << i)) + int'(c)) >> i) & 1;
      check("R6", {31'h0, sum[i]}, {31'h0, x[i] ^ y[i] ^ ci[0]});
    end
  endtask

  initial begin
    logic [15:0] lfsr_a;
    logic [15:0] lfsr_b;
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0;
    opa = 16'h0; opb = 16'h0; cin = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", {16'h0, sum}, 32'h0);      // quiet state under reset
    check("R2", {31'h0, cout}, 32'h0);
    rst_n = 1'b1;

    apply(16'hFFFF, 16'h0001, 1'b0);       // R2 all ones plus one
    check("R2", {31'h0, cout}, 1);
    apply(16'hFFFF, 16'h0000, 1'b1);       // R2/R4 carry-in across all groups
    check("R4", {16'h0, sum}, 32'h0);
    apply(16'h5555, 16'hAAAA, 1'b1);       // R4 every bit passes
    check("R4", {31'h0, cout}, 1);
    apply(16'h5555, 16'hAAAA, 1'b0);       // R4 chain with zero carry-in
    check("R4", {16'h0, sum}, 32'hFFFF);
    apply(16'h000F, 16'h0001, 1'b0);       // R5 group 0 makes carry
    check("R5", {16'h0, sum}, 32'h0010);
    apply(16'h00F0, 16'h0010, 1'b1);       // R5 group 1 makes carry, cin ignored
    check("R5", {16'h0, sum}, 32'h0101);
    apply(16'h8000, 16'h8000, 1'b0);       // R3 top bit makes carry out
    check("R3", {31'h0, cout}, 1);
    apply(16'h0000, 16'h0000, 1'b1);       // R3 0/0 stops carry at bit 0
    check("R3", {16'h0, sum}, 32'h0001);
    apply(16'h0001, 16'h0000, 1'b1);       // R3 0/1 passes carry on
    check("R3", {16'h0, sum}, 32'h0002);

    check_bits(16'h1234, 16'h0FCD, 1'b1);
    check_bits(16'hF0F0, 16'h0F10, 1'b0);

    // R7: response without a clock edge
    @(negedge clk);
    opa = 16'h7FFF; opb = 16'h0001; cin = 1'b0;
    #0.5;
    check("R7", {15'h0, cout, sum}, 32'h08000);

    lfsr_a = 16'hACE1; lfsr_b = 16'h1D2B;
    for (int n = 0; n < 300; n++) begin
      lfsr_a = {lfsr_a[14:0], lfsr_a[15] ^ lfsr_a[13] ^ lfsr_a[12] ^ lfsr_a[10]};
      lfsr_b = {lfsr_b[14:0], lfsr_b[15] ^ lfsr_b[14] ^ lfsr_b[12] ^ lfsr_b[3]};
      apply(lfsr_a, lfsr_b, lfsr_a[0] ^ lfsr_b[7]);
      if (n % 30 == 0) check_bits(lfsr_a, lfsr_b, lfsr_b[2]);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule